// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block paces the clock line of an I2C master. A fixed prescaler divides the core clock into a slower tick. Two nested counters then stretch that tick into SCL half-periods. The inner counter runs over a sample count and the outer counter runs over a step count, so every half-period lasts sample × step divided ticks. Both counts come from one of two configuration words. The normal word serves standard and fast mode. The high-speed word has its own field layout and a narrower step range, and it is selected by a two-bit pattern in its low bits.

The bus sequencer reads the generator's outputs:
- a level that mirrors the intended SCL state;
- one-cycle strobes marking the start of each high half and each low half;
- a sample strobe near the middle of each high half, where SDA is taken;
- a flag showing that high-speed counts are in use.

The block carries no data stream, so every pin is a plain control or status signal with no back-pressure. The configuration words are read only when a half-period begins. A write therefore never produces a shortened or stretched phase.

Top module: `scl_tick_gen`

## Requirements
- R1: While `enable` is low the block is idle: `scl_level` is 1, `hs_active` is 0 and no strobe fires, whatever the configuration words hold.
- R2: The first rising edge that samples `enable` high starts a low half: `scl_low_stb` and `scl_level`=0 appear after that edge.
- R3: Each half-period lasts N × DIV_RATIO clock cycles, where N = sample × step. High and low halves alternate, with `scl_high_stb` (level 1) and `scl_low_stb` (level 0) marking their starts, and the internal counters never pass their programmed limits.
- R4: In normal mode the step count minus one is `norm_timing[5:0]` (1..64) and the sample count minus one is `norm_timing[10:8]` (1..8). All other bits of that word are ignored.
- R5: When `hs_timing[1:0]` is 2'b11, high-speed counts apply and `hs_active` is 1 while running. Sample minus one is `hs_timing[14:12]` and step minus one is `hs_timing[10:8]` (1..8 each). `norm_timing` has no effect in this case.
- R6: Any other value of `hs_timing[1:0]` selects the normal counts and keeps `hs_active` at 0.
- R7: In each high half, `sample_stb` pulses for one cycle after the edge that completes divided tick floor(N/2)+1. When N is 1 this coincides with the next `scl_low_stb`.
- R8: A change to either configuration word during a half-period takes effect only at the next half-period boundary.
- R9: Dropping `enable` returns the block to idle at the next edge: `scl_level` goes to 1 and no later strobe fires.
- R10: `scl_high_stb` and `scl_low_stb` never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL pacing when high |
| norm_timing | input | REG_W | Normal-mode count word |
| hs_timing | input | REG_W | High-speed count word and mode select |
| scl_level | output | 1 | Intended SCL level |
| scl_high_stb | output | 1 | One-cycle pulse at the start of a high half |
| scl_low_stb | output | 1 | One-cycle pulse at the start of a low half |
| sample_stb | output | 1 | One-cycle pulse at the middle of a high half |
| hs_active | output | 1 | High-speed counts are in use |

## Verification
The sample strobe and the boundary that ends the high half can land in the same cycle. This happens whenever N is 1: the single divided tick of the high half is both the midpoint tick and the last tick. The bench programs both counts to one, so `sample_stb` and `scl_low_stb` are expected together every period. Its scoreboard queues the sample event ahead of the low-half event at the same cycle number, and the monitor pops strobes in the fixed order high, sample, low, so a missing or misplaced pulse in that shared cycle is reported against R7 or R3.

// File: rtl/scl_tick_pkg.sv
package scl_tick_pkg;
  localparam int SAMP_W    = 3;
  localparam int STEP_W    = 6;
  localparam int HS_STEP_W = 3;
  localparam int SPAN_W    = SAMP_W + STEP_W + 1;

  typedef struct packed {
    logic [SAMP_W-1:0] samp_m1;
    logic [STEP_W-1:0] step_m1;
    logic              hs;
  } phase_cfg_t;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_tick_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0] norm_reg,
  input  logic [REG_W-1:0] hs_reg,
  output phase_cfg_t       cfg
);
  localparam int N_STEP_LO  = 0;
  localparam int N_SAMP_LO  = 8;
  localparam int H_STEP_LO  = 8;
  localparam int H_SAMP_LO  = 12;
  localparam int STEP_PAD   = STEP_W - HS_STEP_W;

  logic hs_sel;
  logic unused_bits;

  assign hs_sel = (hs_reg[1:0] == 2'b11);
  assign unused_bits = ^{norm_reg, hs_reg};

  always_comb begin
    cfg.hs = hs_sel;
    if (hs_sel) begin
      cfg.samp_m1 = hs_reg[H_SAMP_LO +: SAMP_W];
      cfg.step_m1 = {{STEP_PAD{1'b0}}, hs_reg[H_STEP_LO +: HS_STEP_W]};
    end else begin
      cfg.samp_m1 = norm_reg[N_SAMP_LO +: SAMP_W];
      cfg.step_m1 = norm_reg[N_STEP_LO +: STEP_W];
    end
  end
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  phase_cfg_t cfg_in,
  output logic       run,
  output logic       level,
  output logic       hi_stb,
  output logic       lo_stb,
  output logic       smp_stb,
  output logic       hs_act
);
  phase_cfg_t          cfg_q;
  logic [SAMP_W-1:0]   s_cnt;
  logic [STEP_W-1:0]   t_cnt;
  logic [SPAN_W-2:0]   e_cnt;
  logic [SPAN_W-2:0]   mid_q;
  logic [SPAN_W-1:0]   n_in;
  logic                s_last, t_last, bound;

  assign n_in   = (SPAN_W'(cfg_in.samp_m1) + SPAN_W'(1)) *
                  (SPAN_W'(cfg_in.step_m1) + SPAN_W'(1));
  assign s_last = (s_cnt == cfg_q.samp_m1);
  assign t_last = (t_cnt == cfg_q.step_m1);
  assign bound  = tick && s_last && t_last;
  assign hs_act = run && cfg_q.hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; level <= 1'b1;
      hi_stb <= 1'b0; lo_stb <= 1'b0; smp_stb <= 1'b0;
      cfg_q <= '0; mid_q <= '0;
      s_cnt <= '0; t_cnt <= '0; e_cnt <= '0;
    end else begin
      hi_stb <= 1'b0; lo_stb <= 1'b0; smp_stb <= 1'b0;
      if (!enable) begin
        run <= 1'b0; level <= 1'b1;
        s_cnt <= '0; t_cnt <= '0; e_cnt <= '0;
      end else if (!run) begin
        run <= 1'b1; level <= 1'b0; lo_stb <= 1'b1;
        cfg_q <= cfg_in; mid_q <= n_in[SPAN_W-1:1];
        s_cnt <= '0; t_cnt <= '0; e_cnt <= '0;
      end else if (tick) begin
        if (level && (e_cnt == mid_q)) smp_stb <= 1'b1;
        if (bound) begin
          level  <= !level;
          hi_stb <= !level;
          lo_stb <= level;
          cfg_q  <= cfg_in; mid_q <= n_in[SPAN_W-1:1];
          s_cnt <= '0; t_cnt <= '0; e_cnt <= '0;
        end else begin
          e_cnt <= e_cnt + 1'b1;
          if (s_last) begin
            s_cnt <= '0;
            t_cnt <= t_cnt + 1'b1;
          end else begin
            s_cnt <= s_cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_stb, lo_stb})); // R10
  AST_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb |-> level); // R3
  AST_LO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb |-> !level); // R3
  AST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> $past(level)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (s_cnt <= cfg_q.samp_m1) && (t_cnt <= cfg_q.step_m1)); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !hi_stb && !lo_stb) |-> $stable(cfg_q)); // R8
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_tick_pkg::*;
#(
  parameter int DIV_RATIO = 2,
  parameter int REG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [REG_W-1:0] norm_timing,
  input  logic [REG_W-1:0] hs_timing,
  output logic             scl_level,
  output logic             scl_high_stb,
  output logic             scl_low_stb,
  output logic             sample_stb,
  output logic             hs_active
);
  phase_cfg_t cfg_w;
  logic       run_w, tick_w;

  scl_cfg_decode #(.REG_W(REG_W)) u_decode (
    .norm_reg (norm_timing),
    .hs_reg   (hs_timing),
    .cfg      (cfg_w)
  );

  scl_prescale #(.DIV(DIV_RATIO)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .tick  (tick_w)
  );

  scl_phase_ctr u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .tick    (tick_w),
    .cfg_in  (cfg_w),
    .run     (run_w),
    .level   (scl_level),
    .hi_stb  (scl_high_stb),
    .lo_stb  (scl_low_stb),
    .smp_stb (sample_stb),
    .hs_act  (hs_active)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !(scl_high_stb || scl_low_stb || sample_stb)); // R9
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (scl_level && !hs_active)); // R1
endmodule

// File: tb/tb_scl_tick_gen.sv
`timescale 1ns/1ps
module tb_scl_tick_gen;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] norm_timing = '0;
  logic [15:0] hs_timing = '0;
  logic        scl_level, scl_high_stb, scl_low_stb, sample_stb, hs_active;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  int q_cyc[$];
  int q_kind[$];
  bit q_hs[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_tick_gen #(.DIV_RATIO(DIV), .REG_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .norm_timing(norm_timing), .hs_timing(hs_timing),
    .scl_level(scl_level), .scl_high_stb(scl_high_stb),
    .scl_low_stb(scl_low_stb), .sample_stb(sample_stb),
    .hs_active(hs_active)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int k, input bit hs);
    q_cyc.push_back(c); q_kind.push_back(k); q_hs.push_back(hs);
  endtask

  // kind 0 = high start, 1 = sample, 2 = low start (monitor order)
  task automatic mon_one(input int k);
    int ec, ek; bit eh;
    string tg;
    tg = (k == 1) ? {cur_tag, "/R7"} : {cur_tag, "/R3"};
    if (q_cyc.size() == 0) begin
      check(1'b0, tg, "unexpected strobe kind at cycle", cyc, -1);
      return;
    end
    ec = q_cyc.pop_front(); ek = q_kind.pop_front(); eh = q_hs.pop_front();
    check(ek == k, tg, "strobe kind", k, ek);
    check(ec == cyc, tg, "strobe cycle", cyc, ec);
    check(hs_active == eh, tg, "hs_active at strobe", int'(hs_active), int'(eh));
    if (k == 0) check(scl_level == 1'b1, tg, "level at high start", int'(scl_level), 1);
    if (k == 2) check(scl_level == 1'b0, tg, "level at low start", int'(scl_level), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (scl_high_stb) mon_one(0);
      if (sample_stb)   mon_one(1);
      if (scl_low_stb)  mon_one(2);
      if (scl_high_stb && scl_low_stb)
        check(1'b0, "R10", "high and low strobes together", 1, 0);
    end
  end

  task automatic push_high(input int t, input int n, input bit hs);
    push(t, 0, hs);
    push(t + (n / 2 + 1) * DIV, 1, hs);
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic stop_and_check();
    enable = 1'b0;
    @(negedge clk); @(negedge clk);
    check(scl_level == 1'b1, "R9", "level after disable", int'(scl_level), 1);
    check(hs_active == 1'b0, "R9", "hs_active after disable", int'(hs_active), 0);
    check(q_cyc.size() == 0, cur_tag, "missing expected strobes", q_cyc.size(), 0);
  endtask

  // n: expected sample*step, worked out by hand from the field layout
  task automatic run_seq(input logic [15:0] nreg, input logic [15:0] hreg,
                         input int n, input bit hs, input int periods,
                         input string tag);
    int t0, len;
    @(negedge clk);
    cur_tag = tag;
    norm_timing = nreg; hs_timing = hreg;
    enable = 1'b1;
    t0 = cyc + 1;
    len = n * DIV;
    push(t0, 2, hs);
    for (int p = 0; p < periods; p++) begin
      push_high(t0 + (2 * p + 1) * len, n, hs);
      push(t0 + (2 * p + 2) * len, 2, hs);
    end
    wait_cyc(t0 + 2 * periods * len);
    stop_and_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t0, la, lb;
    norm_timing = 16'h0204; hs_timing = 16'h7703;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset/idle state with nonzero configuration words
    check(scl_level == 1'b1, "R1", "idle level", int'(scl_level), 1);
    check(hs_active == 1'b0, "R1", "idle hs_active", int'(hs_active), 0);
    check(!(scl_high_stb || scl_low_stb || sample_stb), "R1", "idle strobes",
          int'({scl_high_stb, scl_low_stb, sample_stb}), 0);
    repeat (20) @(negedge clk);

    // R2/R7: N=1, sample strobe shares a cycle with the low start
    run_seq(16'h0000, 16'h0000, 1, 1'b0, 3, "R2");
    // R3: sample 3, step 5 -> N=15, odd midpoint
    run_seq(16'h0204, 16'h0000, 15, 1'b0, 2, "R3");
    // R4: extra bits ignored, sample 1, step 4 -> N=4
    run_seq(16'hF8C3, 16'h0000, 4, 1'b0, 2, "R4");
    // R4: largest normal counts, sample 8, step 64 -> N=512
    run_seq(16'h073F, 16'h0000, 512, 1'b0, 1, "R4");
    // R5: high-speed sample 2, step 3 -> N=6; normal word ignored
    run_seq(16'h1303, 16'h1203, 6, 1'b1, 2, "R5");
    // R5: high-speed maximum sample 8, step 8 -> N=64
    run_seq(16'h073F, 16'h7703, 64, 1'b1, 1, "R5");
    // R6: low bits 01 keep normal counts: sample 2, step 2 -> N=4
    run_seq(16'h0101, 16'h7701, 4, 1'b0, 2, "R6");

    // R8: change mid-phase from normal N=15 to high-speed N=6
    @(negedge clk);
    cur_tag = "R8";
    norm_timing = 16'h0204; hs_timing = 16'h0000;
    enable = 1'b1;
    t0 = cyc + 1;
    la = 15 * DIV; lb = 6 * DIV;
    push(t0, 2, 1'b0);
    push_high(t0 + la, 6, 1'b1);
    push(t0 + la + lb, 2, 1'b1);
    push_high(t0 + la + 2 * lb, 6, 1'b1);
    push(t0 + la + 3 * lb, 2, 1'b1);
    wait_cyc(t0 + la / 2);
    hs_timing = 16'h1203;
    wait_cyc(t0 + la + 3 * lb);
    stop_and_check();

    // R9: a further idle stretch must stay silent
    cur_tag = "R9";
    repeat (30) @(negedge clk);
    check(q_cyc.size() == 0, "R9", "queue after idle", q_cyc.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule